// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block takes up to 128 already-qualified pending interrupt levels and reduces them to one interrupt request and a readable vector naming the winning source. Each source has an enable bit held in 32-bit mask registers. The lower sources are organised in groups of eight. Each group has a slot register that assigns its members to eight ordered priority positions. Sources above the grouped range rank below every group, in fixed numeric order. A configuration field can name one source that beats all others whenever it is pending and enabled.

Software reaches the block through a small word-addressed register port. Writes take effect on the clock edge. Reads are combinational and have no side effects. The request output and the vector are both registered and are recomputed every cycle from the current pending inputs and register contents, so they always change together. Source number 0 stands for "nothing pending" and can never win.

Top module: `grp_irq_arb`

## Requirements
- R1: After reset every mask register reads 0, the vector reads 0 and `irqReq` is low. Every slot register reads 0x05309770, so slot p holds member p.
- R2: Source s is enabled by bit (31 - s mod 32) of the mask register at address s/32, so the numbering runs MSB-first. Only sources that are both pending and enabled take part in arbitration.
- R3: Group g covers sources 8g to 8g+7 and its slot register sits at address 4+g. Slot p (0 to 3) is the 3-bit field with bit 20+(3-p)*3 as its LSB, and slot p (4 to 7) is the field with bit 4+(7-p)*3 as its LSB. The value in a slot is the member index placed at that position. A lower slot wins, and any member of a lower-numbered group beats every member of a higher-numbered group.
- R4: Reading address 13 returns the winning source number in bits 6:0, with all other bits 0. The value is 0 when no enabled source other than 0 is pending.
- R5: Bits 30:24 of the configuration register at address 12 name an override source. When that source is nonzero, pending and enabled, it wins over every other source. Only those bits are stored, and the other bits read 0.
- R6: Sources 64 to 127 have no slot register. They rank below all grouped sources, and among themselves the lower number wins.
- R7: `irqReq` is high exactly when the vector is nonzero. Both are registered, so a pending change that is present at a clock edge shows at both outputs after that edge.
- R8: The pending input for source 0 is ignored. It never raises `irqReq` and never changes the vector.
- R9: A member that several slots name takes the best of those slots. A member named by no slot ranks below every slotted member of its group, but still above all later groups. Between such unranked members the lower number wins.
- R10: Register reads leave all state unchanged. Writes to the vector address are ignored. Bits of a slot register outside the eight slot fields read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pendIn | input | 128 | Qualified pending level per source |
| regAddr | input | 4 | Word address of the register port |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `regAddr` |
| irqReq | output | 1 | Registered interrupt request |

## Verification
A table drives pending patterns with every source enabled and the default slot order. These patterns separate in-group slot order, ordering between groups, grouped against fixed sources, fixed numeric order and the idle and source-0 cases. Directed tests then change one control at a time. They mask a higher-ranked source to show the mask gates it. They reorder slots in both halves of the field layout to show each half is decoded at its own bit positions. They program duplicate slots to show the rule for unranked members. They set the override to show it beats the ranking and does nothing while its source is idle. A timing case samples both outputs just before and just after the capturing edge.

// File: rtl/grp_irq_arb_pkg.sv
package grp_irq_arb_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_MASK,
    RD_PRIO,
    RD_CFG,
    RD_VEC
  } rdKind_e;

  typedef struct packed {
    logic    maskWr;
    logic    prioWr;
    logic    cfgWr;
    rdKind_e rdKind;
    logic [7:0] idx;
  } strobe_t;

  localparam int SLOT_W = 3;
  localparam int SLOTS  = 8;

  // LSB position of priority slot p inside a group slot register
  function automatic int slotLsb(input int p);
    if (p < 4) return 20 + (3 - p) * 3;
    else       return 4 + (7 - p) * 3;
  endfunction

  // bits covered by the eight slot fields
  function automatic logic [31:0] slotFieldMask();
    logic [31:0] m;
    m = '0;
    for (int p = 0; p < SLOTS; p++) m[slotLsb(p) +: SLOT_W] = '1;
    return m;
  endfunction

  // reset value: slot p holds member p
  function automatic logic [31:0] identitySlots();
    logic [31:0] v;
    v = '0;
    for (int p = 0; p < SLOTS; p++) v[slotLsb(p) +: SLOT_W] = SLOT_W'(p);
    return v;
  endfunction

endpackage

// File: rtl/grp_irq_arb_ctrl.sv
module grp_irq_arb_ctrl
  import grp_irq_arb_pkg::*;
#(
  parameter int MASK_REGS = 4,
  parameter int GRP_COUNT = 8,
  parameter int ADDR_W    = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  output strobe_t           strb
);
  localparam int PRIO_BASE = MASK_REGS;
  localparam int CFG_ADDR  = PRIO_BASE + GRP_COUNT;
  localparam int VEC_ADDR  = CFG_ADDR + 1;

  always_comb begin
    int a;
    a = int'(regAddr);
    strb = '{maskWr: 1'b0, prioWr: 1'b0, cfgWr: 1'b0, rdKind: RD_NONE, idx: 8'd0};
    if (a < MASK_REGS) begin
      strb.rdKind = RD_MASK;
      strb.maskWr = wrEn;
      strb.idx    = 8'(a);
    end else if (a < CFG_ADDR) begin
      strb.rdKind = RD_PRIO;
      strb.prioWr = wrEn;
      strb.idx    = 8'(a - PRIO_BASE);
    end else if (a == CFG_ADDR) begin
      strb.rdKind = RD_CFG;
      strb.cfgWr  = wrEn;
    end else if (a == VEC_ADDR) begin
      strb.rdKind = RD_VEC;
    end
  end
endmodule

// File: rtl/grp_irq_arb_resolve.sv
module grp_irq_arb_resolve
  import grp_irq_arb_pkg::*;
#(
  parameter int NUM_SRC   = 128,
  parameter int GRP_COUNT = 8,
  parameter int VEC_W     = 7
) (
  input  logic [NUM_SRC-1:0]         elig,
  input  logic [GRP_COUNT-1:0][31:0] slotRegs,
  input  logic [VEC_W-1:0]           topSrc,
  output logic [VEC_W-1:0]           winSrc,
  output logic                       anyHit
);
  localparam int FIXED_BASE = GRP_COUNT * SLOTS;

  logic [GRP_COUNT-1:0]        grpHit;
  logic [GRP_COUNT-1:0][2:0]   grpMem;

  // per-group rank resolution
  always_comb begin
    logic [3:0] rank;
    logic [3:0] best;
    logic       hit;
    logic [2:0] mem;
    for (int g = 0; g < GRP_COUNT; g++) begin
      hit  = 1'b0;
      best = 4'd15;
      mem  = 3'd0;
      for (int m = 0; m < SLOTS; m++) begin
        rank = 4'd8;
        for (int p = SLOTS - 1; p >= 0; p--) begin
          if (slotRegs[g][slotLsb(p) +: SLOT_W] == 3'(m)) rank = 4'(p);
        end
        if (elig[g*SLOTS + m] && (!hit || rank < best)) begin
          hit  = 1'b1;
          best = rank;
          mem  = 3'(m);
        end
      end
      grpHit[g] = hit;
      grpMem[g] = mem;
    end
  end

  // fixed range, then groups, then override
  always_comb begin
    winSrc = '0;
    for (int s = NUM_SRC - 1; s >= FIXED_BASE; s--) begin
      if (elig[s]) winSrc = VEC_W'(s);
    end
    for (int g = GRP_COUNT - 1; g >= 0; g--) begin
      if (grpHit[g]) winSrc = VEC_W'(g * SLOTS) + VEC_W'(grpMem[g]);
    end
    if (topSrc != '0 && elig[topSrc]) winSrc = topSrc;
    anyHit = |elig;
  end
endmodule

// File: rtl/grp_irq_arb_dp.sv
module grp_irq_arb_dp
  import grp_irq_arb_pkg::*;
#(
  parameter int NUM_SRC   = 128,
  parameter int GRP_COUNT = 8,
  parameter int MASK_REGS = 4,
  parameter int VEC_W     = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendIn,
  input  strobe_t            strb,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic [VEC_W-1:0]   vecQ,
  output logic               irqQ
);
  localparam logic [31:0] SLOT_MASK  = slotFieldMask();
  localparam logic [31:0] SLOT_RESET = identitySlots();
  localparam int          CFG_LSB    = 24;

  logic [MASK_REGS-1:0][31:0] maskQ;
  logic [GRP_COUNT-1:0][31:0] slotQ;
  logic [VEC_W-1:0]           topQ;
  logic [NUM_SRC-1:0]         maskFlat;
  logic [NUM_SRC-1:0]         elig;
  logic [VEC_W-1:0]           winSrc;
  logic                       anyHit;

  for (genvar i = 0; i < MASK_REGS; i++) begin : g_mask
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) maskQ[i] <= '0;
      else if (strb.maskWr && strb.idx == 8'(i)) maskQ[i] <= wrData;
    end
  end

  for (genvar i = 0; i < GRP_COUNT; i++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) slotQ[i] <= SLOT_RESET;
      else if (strb.prioWr && strb.idx == 8'(i)) slotQ[i] <= wrData & SLOT_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) topQ <= '0;
    else if (strb.cfgWr) topQ <= wrData[CFG_LSB +: VEC_W];
  end

  // MSB-first enable numbering
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_en
    assign maskFlat[s] = maskQ[s / 32][31 - (s % 32)];
  end

  // source 0 means "none" and never competes
  assign elig = pendIn & maskFlat & ~NUM_SRC'(1);

  grp_irq_arb_resolve #(
    .NUM_SRC(NUM_SRC), .GRP_COUNT(GRP_COUNT), .VEC_W(VEC_W)
  ) u_resolve (
    .elig(elig), .slotRegs(slotQ), .topSrc(topQ),
    .winSrc(winSrc), .anyHit(anyHit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecQ <= '0;
      irqQ <= 1'b0;
    end else begin
      vecQ <= winSrc;
      irqQ <= anyHit;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (strb.rdKind)
      RD_MASK: for (int i = 0; i < MASK_REGS; i++) if (strb.idx == 8'(i)) rdData = maskQ[i];
      RD_PRIO: for (int i = 0; i < GRP_COUNT; i++) if (strb.idx == 8'(i)) rdData = slotQ[i];
      RD_CFG:  rdData = 32'(topQ) << CFG_LSB;
      RD_VEC:  rdData = 32'(vecQ);
      default: rdData = '0;
    endcase
  end
endmodule

// File: rtl/grp_irq_arb.sv
module grp_irq_arb
  import grp_irq_arb_pkg::*;
#(
  parameter int NUM_SRC   = 128,
  parameter int GRP_COUNT = 8,
  parameter int MASK_REGS = NUM_SRC / 32,
  parameter int VEC_W     = $clog2(NUM_SRC),
  parameter int ADDR_W    = $clog2(MASK_REGS + GRP_COUNT + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               irqReq
);
  strobe_t          strb;
  logic [VEC_W-1:0] vecQ;

  grp_irq_arb_ctrl #(
    .MASK_REGS(MASK_REGS), .GRP_COUNT(GRP_COUNT), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .regAddr(regAddr), .wrEn(wrEn), .strb(strb)
  );

  grp_irq_arb_dp #(
    .NUM_SRC(NUM_SRC), .GRP_COUNT(GRP_COUNT), .MASK_REGS(MASK_REGS), .VEC_W(VEC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pendIn(pendIn), .strb(strb), .wrData(wrData),
    .rdData(rdData), .vecQ(vecQ), .irqQ(irqReq)
  );
endmodule

// File: rtl/grp_irq_arb_chk.sv
module grp_irq_arb_chk #(
  parameter int NUM_SRC = 128,
  parameter int VEC_W   = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] pendIn,
  input logic               irqReq,
  input logic [VEC_W-1:0]   vecQ
);
  logic [NUM_SRC-1:0] pendPrev;
  logic               seenQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendPrev <= '0;
      seenQ    <= 1'b0;
    end else begin
      pendPrev <= pendIn;
      seenQ    <= 1'b1;
    end
  end

  a_r7_irq_tracks_vec: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (vecQ != '0));

  a_r2_winner_was_pending: assert property (@(posedge clk) disable iff (!rstN)
    (seenQ && irqReq) |-> pendPrev[vecQ]);

  a_r4_zero_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    (seenQ && pendPrev[NUM_SRC-1:1] == '0) |-> (vecQ == '0));

  a_r8_src0_alone_silent: assert property (@(posedge clk) disable iff (!rstN)
    (seenQ && pendPrev == NUM_SRC'(1)) |-> !irqReq);
endmodule

bind grp_irq_arb grp_irq_arb_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rstN(rstN), .pendIn(pendIn), .irqReq(irqReq), .vecQ(vecQ)
);

// File: tb/grp_irq_arb_tb.sv
`timescale 1ns/1ps
module grp_irq_arb_tb;
  localparam int VEC_ADDR = 13;
  localparam int CFG_ADDR = 12;

  logic         clk = 1'b0;
  logic         rstN;
  logic [127:0] pendIn;
  logic [3:0]   regAddr;
  logic         wrEn;
  logic [31:0]  wrData;
  logic [31:0]  rdData;
  logic         irqReq;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  grp_irq_arb u_dut (
    .clk(clk), .rstN(rstN), .pendIn(pendIn), .regAddr(regAddr),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irqReq(irqReq)
  );

  typedef struct packed {
    logic [127:0] pend;
    logic [6:0]   vec;
  } row_t;

  function automatic logic [127:0] b(input int n);
    return 128'd1 << n;
  endfunction

  // all sources enabled, default slot order
  localparam row_t TABLE [8] = '{
    '{pend: (128'd1 << 5)  | (128'd1 << 70),  vec: 7'd5},
    '{pend: (128'd1 << 70) | (128'd1 << 100), vec: 7'd70},
    '{pend: (128'd1 << 9)  | (128'd1 << 63),  vec: 7'd9},
    '{pend: (128'd1 << 15) | (128'd1 << 16),  vec: 7'd15},
    '{pend: (128'd1 << 127),                  vec: 7'd127},
    '{pend: 128'd0,                           vec: 7'd0},
    '{pend: 128'd1,                           vec: 7'd0},
    '{pend: 128'd3,                           vec: 7'd1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic readReg(input int addr, output logic [31:0] val);
    regAddr = 4'(addr);
    #1;
    val = rdData;
  endtask

  task automatic writeReg(input int addr, input logic [31:0] val);
    regAddr = 4'(addr);
    wrData  = val;
    wrEn    = 1'b1;
    @(negedge clk);
    wrEn    = 1'b0;
  endtask

  task automatic setPend(input logic [127:0] v);
    pendIn = v;
    @(negedge clk);
  endtask

  task automatic checkVec(input string tag, input int exp);
    logic [31:0] v;
    readReg(VEC_ADDR, v);
    check(tag, v, 32'(exp));
    check({tag, " irq"}, {31'd0, irqReq}, {31'd0, exp != 0});
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] v2;
    rstN = 1'b0; pendIn = '0; regAddr = '0; wrEn = 1'b0; wrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      readReg(i, v);
      check("R1 mask reset", v, 32'h0);
    end
    readReg(4, v);
    check("R1 slot reset", v, 32'h05309770);
    readReg(11, v);
    check("R1 slot reset last group", v, 32'h05309770);
    checkVec("R1 vector reset", 0);

    // R2 masks gate arbitration
    setPend(b(5) | b(40));
    @(negedge clk);
    checkVec("R2 all masked", 0);
    writeReg(1, 32'h0080_0000);          // source 40 -> reg 1 bit 23
    @(negedge clk);
    checkVec("R2 only source 40 enabled", 40);
    for (int i = 0; i < 4; i++) writeReg(i, 32'hFFFF_FFFF);

    // table walk: R3/R6/R8
    for (int r = 0; r < 8; r++) begin
      setPend(TABLE[r].pend);
      @(negedge clk);
      checkVec($sformatf("R3/R6/R8 table row %0d", r), int'(TABLE[r].vec));
    end

    // R7 registered timing: vector still 1 from last row
    pendIn = b(20);
    #1;
    checkVec("R7 before capture edge", 1);
    @(negedge clk);
    checkVec("R7 after capture edge", 20);
    pendIn = '0;
    @(negedge clk);
    checkVec("R7 request drops", 0);

    // R3 reprogrammed slots for group 0: 6,2,0,1,3,4,5,7
    writeReg(4, 32'hC810_72F0);
    readReg(4, v);
    check("R10 slot readback", v, 32'hC810_72F0);
    setPend(b(2) | b(6) | b(7)); @(negedge clk);
    checkVec("R3 slot0 member 6", 6);
    setPend(b(2) | b(3)); @(negedge clk);
    checkVec("R3 slot1 beats slot4", 2);
    setPend(b(3) | b(5)); @(negedge clk);
    checkVec("R3 slot4 beats slot6", 3);
    setPend(b(5) | b(7)); @(negedge clk);
    checkVec("R3 slot6 beats slot7", 5);

    // R9 duplicate slots: every slot names member 3
    writeReg(4, 32'hFFFF_FFFF & 32'h6DB0_6DB0);
    setPend(b(3) | b(7)); @(negedge clk);
    checkVec("R9 slotted member wins", 3);
    setPend(b(5) | b(7)); @(negedge clk);
    checkVec("R9 unranked lower number", 5);
    setPend(b(5) | b(9)); @(negedge clk);
    checkVec("R9 unranked above next group", 5);
    writeReg(4, 32'hFFFF_FFFF);
    readReg(4, v);
    check("R10 slot unused bits read 0", v, 32'hFFF0_FFF0);
    writeReg(4, 32'h0530_9770);

    // R5 override
    writeReg(CFG_ADDR, 32'h6400_0000);
    readReg(CFG_ADDR, v);
    check("R5 cfg readback", v, 32'h6400_0000);
    setPend(b(1) | b(100)); @(negedge clk);
    checkVec("R5 override wins", 100);
    setPend(b(1)); @(negedge clk);
    checkVec("R5 idle override no effect", 1);
    writeReg(CFG_ADDR, 32'hFFFF_FFFF);
    readReg(CFG_ADDR, v);
    check("R5 cfg unused bits read 0", v, 32'h7F00_0000);
    setPend(b(1) | b(127)); @(negedge clk);
    checkVec("R5 override fixed source", 127);

    // R10 vector write ignored, reads side-effect free; R4 full word
    writeReg(VEC_ADDR, 32'h0000_0000);
    @(negedge clk);
    readReg(VEC_ADDR, v);
    readReg(VEC_ADDR, v2);
    check("R10 vector write ignored", v, 32'd127);
    check("R4 repeated read equal", v2, v);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule